// File: doc/BRIEF.md
# Three-Wire Serial Memory Read Slave

This block is the device side of a three-wire serial memory with chip select, serial clock and serial data in and out. While chip select is high it collects an instruction from the data-in line, one bit per rising edge of the serial clock. An instruction is a start bit, a two-bit opcode and an address. When the opcode is a read, the block drives one zero bit on data-out. It then shifts out the addressed word, most significant bit first, and moves on to the next addresses for as long as chip select stays high. At the top of the array the address wraps back to zero.

An organization input selects 16-bit words or 8-bit words. The storage is a byte array with a preload port that fills it for test. The serial inputs are sampled in the system clock domain. The serial clock is oversampled and its rising edges are found by comparing it with its value one cycle earlier. Data-out carries an enable that marks when the line is actually driven.

Top module: `mw_serial_mem`

## Requirements
- R1: While chip select is high, `di_i` is sampled on each rising edge of `sk_i`. Zeros before the first 1 are ignored and leave `do_oe_o` low. The first 1 is the start bit. After it come two opcode bits and then the address, most significant bit first.
- R2: The address is WIDE_AW bits (default 6) when `org16_i` is 1 and WIDE_AW+1 bits (default 7) when `org16_i` is 0.
- R3: With opcode 10 (first opcode bit 1, second 0), the rising edge that samples the last address bit makes `do_oe_o` go to 1 with `do_o` = 0 within one system clock. That zero is a dummy bit.
- R4: Each later rising edge of `sk_i` presents the next data bit on `do_o`, most significant bit first. In 16-bit mode the word at address a is {byte[2a], byte[2a+1]}. In 8-bit mode it is byte[a]. `di_i` is ignored during output.
- R5: After the last bit of a word, the next rising edge gives the first bit of the word at the next address, with no new instruction. The address wraps from the top word (63 in 16-bit mode, 127 in 8-bit mode by default) to 0.
- R6: Chip select low clears `do_oe_o` within one system clock and returns the decoder to waiting for a start bit. A full instruction can follow as soon as chip select rises again.
- R7: Opcodes 00, 01 and 11 produce no output. `do_oe_o` stays low until chip select falls.
- R8: While `sk_i` is held at either level, `do_o` and `do_oe_o` hold their values. The read then goes on correctly once the clock resumes.
- R9: `do_o` is 0 whenever `do_oe_o` is 0, and both are 0 after reset.
- R10: `pl_we_i` writes `pl_data_i` into byte `pl_addr_i` at a system clock edge. Later reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the serial inputs are sampled with it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sk_i | input | 1 | Serial clock |
| cs_i | input | 1 | Chip select, active high |
| di_i | input | 1 | Serial data in |
| org16_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| pl_we_i | input | 1 | Preload write strobe |
| pl_addr_i | input | WIDE_AW+1 | Preload byte address |
| pl_data_i | input | 8 | Preload byte |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Data-out enable; low means the line is released |

## Verification
The assertions assume the following about the inputs:
- `sk_i`, `cs_i` and `di_i` change in step with the system clock.
- Each serial clock level lasts at least two system cycles.
- `org16_i` changes only while chip select is low.
- Preload writes happen outside reads.

Under these assumptions, output changes can be traced to a detected serial edge or to chip select falling. The bench keeps within these limits:
- It drives every input on the falling system clock edge.
- It holds each serial phase for two to three cycles.
- It changes the organization and preloads only with chip select low.
- It randomises the start address, the number of leading zeros and the read length, and adds directed wrap, abort, stall and non-read cases.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_DONE
  } dec_state_e;

  localparam logic [1:0] OP_READ = 2'b10;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
endpackage

// File: rtl/mw_decoder.sv
module mw_decoder
  import mw_pkg::*;
#(
  parameter int WIDE_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               rise_i,
  input  logic               di_i,
  input  logic               org16_i,
  output logic               rd_go_o,
  output logic [WIDE_AW:0]   rd_addr_o
);
  localparam int NARROW_AW = WIDE_AW + 1;
  localparam int CW        = $clog2(NARROW_AW);

  dec_state_e            st_q;
  logic [1:0]            op_q;
  logic [CW-1:0]         cnt_q;
  logic [NARROW_AW-2:0]  asr_q;
  logic                  last_bit;

  assign last_bit  = cnt_q == (org16_i ? CW'(WIDE_AW - 1) : CW'(NARROW_AW - 1));
  // R3: launch on the same edge that samples the last address bit
  assign rd_go_o   = cs_i && rise_i && (st_q == ST_ADR) && last_bit && (op_q == OP_READ);
  assign rd_addr_o = {asr_q, di_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      op_q  <= '0;
      cnt_q <= '0;
      asr_q <= '0;
    end else if (!cs_i) begin   // R6
      st_q  <= ST_IDLE;
      op_q  <= '0;
      cnt_q <= '0;
      asr_q <= '0;
    end else if (rise_i) begin
      unique case (st_q)
        ST_IDLE: if (di_i) st_q <= ST_OPC;   // R1: leading zeros skipped
        ST_OPC: begin
          op_q <= {op_q[0], di_i};
          if (cnt_q == CW'(1)) begin
            st_q  <= ST_ADR;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ADR: begin
          asr_q <= {asr_q[NARROW_AW-3:0], di_i};
          cnt_q <= cnt_q + 1'b1;
          if (last_bit) st_q <= ST_DONE;   // R7: non-read parks here
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mw_store.sv
module mw_store
  import mw_pkg::*;
#(
  parameter int WIDE_AW = 6
) (
  input  logic               clk_i,
  input  logic               pl_we_i,
  input  logic [WIDE_AW:0]   pl_addr_i,
  input  logic [BYTE_W-1:0]  pl_data_i,
  input  logic               org16_i,
  input  logic [WIDE_AW:0]   addr_i,
  output logic [WORD_W-1:0]  word_o
);
  localparam int NARROW_AW = WIDE_AW + 1;
  localparam int DEPTH     = 2 ** NARROW_AW;

  logic [BYTE_W-1:0]    mem_q [DEPTH];
  logic [NARROW_AW-1:0] hi_idx, lo_idx;

  always_ff @(posedge clk_i) begin
    if (pl_we_i) mem_q[pl_addr_i] <= pl_data_i;   // R10
  end

  // R4: even byte is the upper half in 16-bit mode; 8-bit words are left aligned
  assign hi_idx = org16_i ? {addr_i[NARROW_AW-2:0], 1'b0} : addr_i;
  assign lo_idx = {addr_i[NARROW_AW-2:0], 1'b1};
  assign word_o = org16_i ? {mem_q[hi_idx], mem_q[lo_idx]} : {mem_q[hi_idx], {BYTE_W{1'b0}}};
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter
  import mw_pkg::*;
#(
  parameter int WIDE_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               rise_i,
  input  logic               org16_i,
  input  logic               rd_go_i,
  input  logic [WIDE_AW:0]   rd_addr_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [WIDE_AW:0]   fetch_addr_o,
  output logic               do_o,
  output logic               oe_o
);
  localparam int NARROW_AW = WIDE_AW + 1;
  localparam logic [NARROW_AW-1:0] WRAP16 = {1'b0, {WIDE_AW{1'b1}}};

  logic [WORD_W-1:0]    sr_q;
  logic [3:0]           bc_q;
  logic [NARROW_AW-1:0] addr_q, addr_inc, addr_nxt;
  logic                 do_q, act_q;
  logic [3:0]           bc_last;

  assign bc_last      = org16_i ? 4'd15 : 4'd7;
  assign addr_inc     = addr_q + 1'b1;
  assign addr_nxt     = org16_i ? (addr_inc & WRAP16) : addr_inc;   // R5
  assign fetch_addr_o = rd_go_i ? rd_addr_i : addr_nxt;
  assign do_o         = do_q;
  assign oe_o         = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bc_q   <= '0;
      addr_q <= '0;
      do_q   <= 1'b0;
      act_q  <= 1'b0;
    end else if (!cs_i) begin
      do_q   <= 1'b0;
      act_q  <= 1'b0;
    end else if (rd_go_i) begin
      act_q  <= 1'b1;
      do_q   <= 1'b0;   // R3 dummy bit
      sr_q   <= word_i;
      addr_q <= rd_addr_i;
      bc_q   <= '0;
    end else if (act_q && rise_i) begin
      do_q <= sr_q[WORD_W-1];
      if (bc_q == bc_last) begin
        sr_q   <= word_i;
        addr_q <= addr_nxt;
        bc_q   <= '0;
      end else begin
        sr_q <= sr_q << 1;
        bc_q <= bc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mw_serial_mem.sv
module mw_serial_mem
  import mw_pkg::*;
#(
  parameter int WIDE_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sk_i,
  input  logic               cs_i,
  input  logic               di_i,
  input  logic               org16_i,
  input  logic               pl_we_i,
  input  logic [WIDE_AW:0]   pl_addr_i,
  input  logic [BYTE_W-1:0]  pl_data_i,
  output logic               do_o,
  output logic               do_oe_o
);
  logic               sk_q, sk_rise, rd_go;
  logic [WIDE_AW:0]   rd_addr, fetch_addr;
  logic [WORD_W-1:0]  word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sk_q <= 1'b0;
    else         sk_q <= sk_i;
  end
  assign sk_rise = sk_i & ~sk_q;

  mw_decoder #(.WIDE_AW(WIDE_AW)) u_dec (
    .clk_i, .rst_ni, .cs_i, .rise_i(sk_rise), .di_i, .org16_i,
    .rd_go_o(rd_go), .rd_addr_o(rd_addr)
  );

  mw_store #(.WIDE_AW(WIDE_AW)) u_store (
    .clk_i, .pl_we_i, .pl_addr_i, .pl_data_i, .org16_i,
    .addr_i(fetch_addr), .word_o(word)
  );

  mw_shifter #(.WIDE_AW(WIDE_AW)) u_shf (
    .clk_i, .rst_ni, .cs_i, .rise_i(sk_rise), .org16_i,
    .rd_go_i(rd_go), .rd_addr_i(rd_addr), .word_i(word),
    .fetch_addr_o(fetch_addr), .do_o, .oe_o(do_oe_o)
  );
endmodule

// File: rtl/mw_serial_mem_chk.sv
module mw_serial_mem_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sk_i,
  input logic cs_i,
  input logic do_o,
  input logic do_oe_o
);
  logic sk_d, rise_c;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sk_d <= 1'b0;
    else         sk_d <= sk_i;
  end
  assign rise_c = sk_i & ~sk_d;

  AST_DUMMY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(do_oe_o) |-> !do_o);  // R3
  AST_CS_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !do_oe_o);  // R6
  AST_OE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_oe_o |-> $past(cs_i));  // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !rise_c) |=> ($stable(do_o) && $stable(do_oe_o)));  // R8
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !do_oe_o |-> !do_o);  // R9
endmodule

bind mw_serial_mem mw_serial_mem_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sk_i(sk_i), .cs_i(cs_i),
  .do_o(do_o), .do_oe_o(do_oe_o)
);

// File: tb/mw_serial_mem_tb.sv
module mw_serial_mem_tb;
  localparam int AW16 = 6;
  localparam int AW8  = AW16 + 1;
  localparam int NB   = 2 ** AW8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sk = 1'b0, cs = 1'b0, di = 1'b0, org16 = 1'b1;
  logic pl_we = 1'b0;
  logic [AW8-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic do_w, oe_w;
  logic [7:0] bm [NB];
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  mw_serial_mem #(.WIDE_AW(AW16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sk_i(sk), .cs_i(cs), .di_i(di), .org16_i(org16),
    .pl_we_i(pl_we), .pl_addr_i(pl_addr), .pl_data_i(pl_data),
    .do_o(do_w), .do_oe_o(oe_w)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(int a, bit o16);
    if (o16) return {bm[2*a], bm[2*a+1]};
    return {8'h00, bm[a]};
  endfunction

  task automatic preload(int a, logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = AW8'(a); pl_data = d; bm[a] = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    di = b; sk = 1'b0;
    repeat (2) @(negedge clk);
    sk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic stall();
    logic held;
    held = do_w;
    repeat (12) begin
      @(negedge clk);
      chk("R8 hold high", {14'd0, oe_w, do_w}, {14'd0, 1'b1, held});
    end
    sk = 1'b0;
    repeat (12) begin
      @(negedge clk);
      chk("R8 hold low", {14'd0, oe_w, do_w}, {14'd0, 1'b1, held});
    end
  endtask

  task automatic end_cs();
    @(negedge clk);
    cs = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 oe off", {15'd0, oe_w}, 16'd0);
    chk("R9 do low", {15'd0, do_w}, 16'd0);
  endtask

  task automatic start_instr(bit o16, logic [1:0] op, int a, int nlead);
    int aw;
    @(negedge clk);
    org16 = o16; cs = 1'b1; sk = 1'b0; di = 1'b0;
    repeat (nlead) send_bit(1'b0);
    if (nlead > 0) chk("R1 leading zeros", {15'd0, oe_w}, 16'd0);
    send_bit(1'b1);
    send_bit(op[1]);
    send_bit(op[0]);
    aw = o16 ? AW16 : AW8;
    for (int i = aw - 1; i >= 0; i--) send_bit(1'((a >> i) & 1));
  endtask

  task automatic do_read(bit o16, int a, int nbits, int nlead, int stall_at);
    int wl, cur, b;
    logic [15:0] w;
    start_instr(o16, 2'b10, a, nlead);
    chk("R3 oe on", {15'd0, oe_w}, 16'd1);
    chk("R3 dummy zero", {15'd0, do_w}, 16'd0);
    wl = o16 ? 16 : 8;
    cur = a;
    b = 0;
    w = exp_word(cur, o16);
    for (int k = 0; k < nbits; k++) begin
      send_bit(1'($urandom % 2));
      if (k == stall_at) stall();
      if (k < wl) chk("R4 data bit", {15'd0, do_w}, {15'd0, w[wl-1-b]});
      else        chk("R5 next word bit", {15'd0, do_w}, {15'd0, w[wl-1-b]});
      b++;
      if (b == wl) begin
        b = 0;
        cur = (cur + 1) % (o16 ? (NB / 2) : NB);
        w = exp_word(cur, o16);
      end
    end
    end_cs();
  endtask

  task automatic do_other(bit o16, logic [1:0] op, int a);
    start_instr(o16, op, a, 0);
    for (int k = 0; k < 20; k++) begin
      send_bit(1'($urandom % 2));
      chk("R7 no output", {14'd0, oe_w, do_w}, 16'd0);
    end
    end_cs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(negedge clk);
    chk("R9 reset oe", {15'd0, oe_w}, 16'd0);
    chk("R9 reset do", {15'd0, do_w}, 16'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) preload(i, 8'($urandom));

    do_read(1'b1, 0, 32, 0, -1);                // R4 R5
    do_read(1'b1, AW16 == 6 ? 63 : 0, 32, 2, -1); // R5 wrap 16-bit
    do_read(1'b0, NB - 1, 24, 0, -1);            // R2 R5 wrap 8-bit
    do_read(1'b0, 5, 16, 5, 3);                  // R1 R8
    do_read(1'b1, 17, 20, 1, 9);                 // R8
    do_other(1'b1, 2'b00, 3);                    // R7
    do_other(1'b0, 2'b01, 40);                   // R7
    do_other(1'b1, 2'b11, 63);                   // R7
    do_read(1'b1, 9, 5, 0, -1);                  // R6 abort mid-word
    do_read(1'b1, 9, 16, 0, -1);                 // R6 restart
    preload(22, 8'hA5);                          // R10
    preload(23, 8'h3C);
    do_read(1'b0, 22, 16, 0, -1);                // R10 readback 8-bit
    do_read(1'b1, 11, 16, 0, -1);                // R10 readback 16-bit
    for (int it = 0; it < 24; it++) begin
      bit o;
      o = 1'($urandom % 2);
      do_read(o, int'($urandom % (o ? NB / 2 : NB)), 1 + int'($urandom % 40),
              int'($urandom % 4), -1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule